// File: doc/BRIEF.md
# UART Receive Line Error Status

This block gathers the error indications a UART receiver raises for each character and presents them to the host as one 12-bit status word. Reading the word clears it. The receiver reports each completed character with a strobe. Alongside that strobe come three qualifiers: framing error, parity error and break. The block also takes a level that is high while a break is currently on the line, and it tracks the receive FIFO occupancy through its own tag queue. From that occupancy it detects overruns itself. The data FIFO lives outside the block and moves in step with the same push and pop strobes.

There are two reporting modes. In the default mode, the break, framing, parity and overrun flags are sticky history. They are not tied to any stored byte, and one read clears them all. In wide mode, the break, framing and parity bits show the tags of the byte at the head of the receive FIFO, so each error can be matched to its own byte. Overrun stays a sticky event in both modes. A separate bit always shows the current break level, delayed by one register.

Top module: `uart_line_err_status`

## Requirements
- R1: After a synchronous reset, the status word reads 12'h000 while the break level is low.
- R2: Bits [2:0] and [11:8] of the status word always read zero.
- R3: In default mode, a completed character with an error qualifier sets the matching flag at the next clock edge. Break sets bit 3, framing sets bit 4 and parity sets bit 5. The flag then holds until a read.
- R4: During the cycle in which the read strobe is high, the status word shows the value from before the clear. From the next edge on, the sticky flags in bits 3 to 6 are zero unless a new event arrived.
- R5: An event that arrives in the same cycle as a read is still set after that read.
- R6: A completed character that arrives while the queue holds DEPTH entries and no pop is present is an overrun. It sets bit 6 and is dropped, so queue occupancy does not change. A push that coincides with a pop is never an overrun.
- R7: Bit 7 follows the break level one cycle later, and a read does not clear it.
- R8: In wide mode, bits 3, 4 and 5 show the break, framing and parity tags of the head entry, and they read zero when the queue is empty. They change one edge after the head changes, through a push into an empty queue or a pop.
- R9: In wide mode, a read leaves bits 3 to 5 unchanged and clears the overrun bit 6.
- R10: A pop while the queue is empty is ignored. The next pushed character becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = per-byte reporting, 0 = sticky history |
| rx_done | input | 1 | Character completed strobe; also pushes the tag queue |
| rx_frm_err | input | 1 | Stop bit missing for this character (qualifies rx_done) |
| rx_par_err | input | 1 | Parity mismatch for this character (qualifies rx_done) |
| rx_brk | input | 1 | Character was a break (qualifies rx_done) |
| brk_live | input | 1 | High while a break is currently seen on the line |
| fifo_pop | input | 1 | Head byte of the receive FIFO consumed |
| stat_rd | input | 1 | Single-cycle status read strobe |
| status | output | 12 | Status word |

## Verification
On every cycle, the assertions check the sticky flag set and clear rules, including the case where an event meets a read in the same cycle. They also check the one-cycle tracking of the break level, the overrun path (occupancy held and bit 6 raised), the bound on queue occupancy, and that wide-mode tag bits stay stable across a read. Only the bench scenarios can show that the head tags follow the right entry in order, that a dropped character never reaches the head, that empty-queue pops leave no trace, and that history gathered in wide mode appears once the block returns to default mode.

// File: rtl/uart_les_pkg.sv
package uart_les_pkg;
  localparam int STAT_W   = 12;
  localparam int BIT_BRK  = 3;
  localparam int BIT_FRM  = 4;
  localparam int BIT_PAR  = 5;
  localparam int BIT_OVR  = 6;
  localparam int BIT_LIVE = 7;
  localparam int N_FLAGS  = 4;   // sticky flags, index 0..3 map to status bits 3..6
  localparam int TAG_W    = 3;

  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } err_tag_t;
endpackage

// File: rtl/uart_les_sticky.sv
module uart_les_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end

    // an event in a clearing cycle must survive
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/uart_les_tagq.sv
module uart_les_tagq
  import uart_les_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  logic     pop,
  input  err_tag_t tag_in,
  output err_tag_t head,
  output logic     drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr, rptr_nx;
  logic [CW-1:0]    cnt, cnt_nx;
  logic             empty, full, do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_IX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == FULL_CNT);
    do_pop  = pop & ~empty;
    do_push = push & (~full | do_pop);
    drop    = push & full & ~do_pop;
    rptr_nx = do_pop ? nxt(rptr) : rptr;
    cnt_nx  = cnt + CW'(do_push) - CW'(do_pop);
  end

  // tag storage, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      head <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      rptr <= rptr_nx;
      cnt  <= cnt_nx;
      if (cnt_nx == '0)
        head <= '0;
      else if (do_push && (empty || (cnt == CW'(1) && do_pop)))
        head <= tag_in;              // new byte lands straight at the head
      else
        head <= err_tag_t'(mem[rptr_nx]);
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  assert_drop_holds_cnt_R6: assert property (@(posedge clk) disable iff (rst)
    drop |=> (cnt == FULL_CNT));
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/uart_line_err_status.sv
module uart_line_err_status
  import uart_les_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              rx_done,
  input  logic              rx_frm_err,
  input  logic              rx_par_err,
  input  logic              rx_brk,
  input  logic              brk_live,
  input  logic              fifo_pop,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] status
);
  err_tag_t             in_tag, head;
  logic                 drop, live_q;
  logic [N_FLAGS-1:0]   ev, flags;

  assign in_tag = '{brk: rx_brk, par: rx_par_err, frm: rx_frm_err};
  // index 0 brk, 1 frm, 2 par, 3 overrun
  assign ev = {drop, rx_done & rx_par_err, rx_done & rx_frm_err, rx_done & rx_brk};

  uart_les_tagq #(.DEPTH(DEPTH)) u_tagq (
    .clk(clk), .rst(rst), .push(rx_done), .pop(fifo_pop),
    .tag_in(in_tag), .head(head), .drop(drop)
  );

  uart_les_sticky #(.N(N_FLAGS)) u_sticky (
    .clk(clk), .rst(rst), .set(ev), .clr(stat_rd), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= brk_live;
  end

  always_comb begin
    status           = '0;
    status[BIT_LIVE] = live_q;
    status[BIT_OVR]  = flags[3];
    if (wide_mode) begin
      status[BIT_BRK] = head.brk;
      status[BIT_FRM] = head.frm;
      status[BIT_PAR] = head.par;
    end else begin
      status[BIT_BRK] = flags[0];
      status[BIT_FRM] = flags[1];
      status[BIT_PAR] = flags[2];
    end
  end

  assert_live_track_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[BIT_LIVE] == $past(brk_live)));
  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (rst)
    drop |=> status[BIT_OVR]);
  assert_wide_read_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && stat_rd && !rx_done && !fifo_pop) |=>
      (!wide_mode || $stable(status[BIT_PAR:BIT_BRK])));
endmodule

// File: tb/test_uart_line_err_status.sv
module test_uart_line_err_status;
  localparam int DEPTH = 16;
  localparam int NV    = 27;

  logic        clk = 1'b0;
  logic        rst, wide_mode, rx_done, rx_frm_err, rx_par_err, rx_brk;
  logic        brk_live, fifo_pop, stat_rd;
  logic [11:0] status;
  int          checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_line_err_status #(.DEPTH(DEPTH)) i_uart_line_err_status (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .rx_done(rx_done),
    .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_brk(rx_brk),
    .brk_live(brk_live), .fifo_pop(fifo_pop), .stat_rd(stat_rd), .status(status)
  );

  // {req[3:0], wide, done, brk, par, frm, pop, rd, live, expected[11:0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'd3,  8'b01001000, 12'h010},  // R3 framing
    {4'd3,  8'b00000000, 12'h010},  // R3 held
    {4'd3,  8'b01010000, 12'h030},  // R3 parity
    {4'd4,  8'b00000010, 12'h000},  // R4 cleared
    {4'd5,  8'b01100010, 12'h008},  // R5 break during read
    {4'd7,  8'b00000001, 12'h088},  // R7 live break
    {4'd7,  8'b00000011, 12'h080},  // R7 survives read
    {4'd7,  8'b00000000, 12'h000},  // R7 drops
    {4'd8,  8'b10000000, 12'h010},  // R8 head framing
    {4'd8,  8'b10000100, 12'h020},  // R8 head parity
    {4'd9,  8'b10000010, 12'h020},  // R9 read keeps tag
    {4'd8,  8'b10000100, 12'h008},  // R8 head break
    {4'd8,  8'b10000100, 12'h000},  // R8 empty
    {4'd10, 8'b10000100, 12'h000},  // R10 empty pop
    {4'd8,  8'b11000000, 12'h000},  // R8 clean byte
    {4'd8,  8'b11011000, 12'h000},  // R8 second byte not head
    {4'd8,  8'b10000100, 12'h030},  // R8 second byte now head
    {4'd3,  8'b00000000, 12'h030},  // R3 history from wide mode
    {4'd4,  8'b00000010, 12'h000},  // R4
    {4'd10, 8'b00000100, 12'h000},  // R10 last pop
    {4'd10, 8'b00000100, 12'h000},  // R10 empty pop
    {4'd10, 8'b11000000, 12'h000},  // R10 clean head
    {4'd8,  8'b11100000, 12'h000},  // R8 break byte behind
    {4'd8,  8'b10000100, 12'h008},  // R8
    {4'd8,  8'b10000100, 12'h000},  // R8
    {4'd3,  8'b00000000, 12'h008},  // R3 sticky break
    {4'd4,  8'b00000010, 12'h000}   // R4
  };

  task automatic check(input logic [11:0] exp, input int req, input string what);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL R%0d %s: status=%h expected=%h", req, what, status, exp);
    end
  endtask

  task automatic drive(input logic [7:0] c);
    {wide_mode, rx_done, rx_brk, rx_par_err, rx_frm_err, fifo_pop, stat_rd, brk_live} = c;
  endtask

  task automatic step(input logic [7:0] c);
    drive(c);
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired: cycles=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    drive(8'h00);
    repeat (3) @(posedge clk);
    #2;
    check(12'h000, 1, "reset value");           // R1
    rst = 1'b0;
    step(8'h00);
    check(12'h000, 1, "after reset release");   // R1

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:12]);
      check(VEC[i][11:0], int'(VEC[i][23:20]), $sformatf("vector %0d", i));
    end

    // R4: value during the read cycle is the pre-clear value
    step(8'b01001000);
    drive(8'b00000010);
    #3;
    check(12'h010, 4, "value during read");
    @(posedge clk); #2;
    check(12'h000, 4, "after read");

    // R6: fill, then one extra byte overruns and is dropped
    rst = 1'b1; drive(8'h00);
    @(posedge clk); #2;
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) step(8'b01000000);
    check(12'h000, 6, "full queue, no overrun");
    step(8'b01001001);                           // framed byte into full queue, live break on
    check(12'h0D0, 6, "overrun and framing");
    checks++;
    if ((status & 12'hF07) !== 12'h000) begin    // R2 reserved bits
      fails++;
      $display("FAIL R2 reserved bits: status=%h expected=%h", status & 12'hF07, 12'h000);
    end
    step(8'b01000100);                           // R6 push with pop while full
    check(12'h050, 6, "push with pop is no overrun");
    step(8'b00000010);
    step(8'b00000000);
    check(12'h000, 6, "overrun cleared");
    for (int i = 0; i < DEPTH; i++) step(8'b10000100);
    check(12'h000, 6, "dropped byte never reached head");
    step(8'b11000000);                           // overrun again? no: queue empty
    check(12'h000, 6, "no overrun on empty queue");

    // R9: overrun clears on a read in wide mode
    for (int i = 0; i < DEPTH; i++) step(8'b11000000);
    step(8'b11000000);
    check(12'h040, 9, "wide overrun shown");
    step(8'b10000010);
    check(12'h000, 9, "wide read clears overrun");

    finish_run();
  end
endmodule